// File: doc/BRIEF.md
# Line-Spectral Weight Generator

This block computes ten weighting factors from ten line spectral frequency values. A speech encoder uses the factors in its second and third codebook searches. Each factor depends on how close the two neighbours of its position lie to each other. When the neighbours are far enough apart, the factor is exactly one. When they are closer, a penalty is added that grows with the square of the shortfall. The two end positions have no outer neighbour, so each compares against a fixed guard frequency instead. Positions five and six carry an extra gain of 1.2.

A one-cycle `start_i` samples the ten frequencies into the block. From then on the frequencies at the input may change. A single multiplier is shared by all ten positions. A counter steps through the positions, taking two cycles for each plain position and three for each gained one. When the last factor is written, `done_o` pulses for one cycle. The factors stay on `weight_o` until the next accepted start.

Frequencies are signed Q2.13 (radians times 8192) and occupy slice k of `lsf_i` as bits [16k+15:16k], with k = 0 for the first frequency. Weights are Q8.7 (value times 128) and occupy the matching slices of `weight_o`.

Top module: `lsfw_weight_gen`

## Requirements
- R1: For a position p from 2 to 9, the gap term is d = w(p+1) - w(p-1) - 1.0. The weight is 10*d*d + 1 when d < 0 and 1.0 otherwise. The output is within one Q8.7 LSB of the real value, so every weight is at least 128.
- R2: Position 1 uses d = w(2) - G_LO - 1.0, where G_LO is the Q2.13 code 1029 (about 0.04*pi), and then the same rule as R1.
- R3: Position 10 uses d = G_HI - w(9) - 1.0, where G_HI is the Q2.13 code 23677 (about 0.92*pi), and then the same rule as R1.
- R4: After the rule is applied, the weights at positions 5 and 6 are multiplied by 1.2.
- R5: A gap term of zero or more gives a weight of exactly 128 (1.0). At positions 5 and 6 it gives 154.
- R6: The gap term saturates to the 16-bit signed range, so any d below -4.0 is treated as -4.0. Its weight is then 161.0 (or 193.2 at positions 5 and 6), and the output never wraps.
- R7: `done_o` is high for exactly one cycle, 22 clock cycles after the edge that sampled `start_i`. This is within the 60-cycle budget.
- R8: A `start_i` pulse while a computation is running is ignored. After `done_o`, `weight_o` holds its value whatever `lsf_i` does, until the next accepted start.
- R9: While `rst_ni` is low, `done_o` is 0 and `weight_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; samples `lsf_i` when the block is idle |
| lsf_i | input | 160 | Ten Q2.13 signed frequencies; slice k holds the frequency at position k+1 |
| weight_o | output | 160 | Ten Q8.7 weights; slice k holds the weight at position k+1 |
| done_o | output | 1 | One-cycle pulse when all ten weights are valid |

## Verification
The only timing the block promises is that `done_o` rises 22 edges after the edge that took `start_i`. The bench counts falling edges from that point and expects the pulse on exactly the 22nd. It reads all ten weights in that same half cycle and checks each one against a real-valued model, allowing one LSB. For the hold rule, the bench changes `lsf_i` and fires a start while the block is busy. It then waits about thirty more cycles. During that time it checks that no second pulse appears and that the weights still match the first input set.

// File: rtl/lsfw_pkg.sv
package lsfw_pkg;
  parameter int unsigned N_LSF     = 10;
  parameter int unsigned DW        = 16;
  parameter int unsigned IN_FRAC   = 13;
  parameter int unsigned OUT_FRAC  = 7;
  parameter int unsigned GAIN_FRAC = 14;
  parameter int unsigned MW        = 24;
  parameter int unsigned LAT_LIMIT = 60;

  localparam int unsigned IDX_W   = $clog2(N_LSF);
  localparam int unsigned PW      = 2 * MW;
  localparam int unsigned SQ_FRAC = 2 * IN_FRAC;

  localparam logic signed [DW-1:0] LO_GUARD = DW'(1029);
  localparam logic signed [DW-1:0] HI_GUARD = DW'(23677);
  localparam logic signed [DW-1:0] ONE_IN   = DW'(1 << IN_FRAC);
  localparam logic signed [DW-1:0] GAIN_Q   = DW'(19661);
  localparam logic [IDX_W-1:0]     GAIN_IDX_A = IDX_W'(4);
  localparam logic [IDX_W-1:0]     GAIN_IDX_B = IDX_W'(5);
  localparam logic [IDX_W-1:0]     LAST_IDX   = IDX_W'(N_LSF - 1);

  localparam logic signed [PW-1:0] ONE_SQ = PW'(1) <<< SQ_FRAC;
  localparam logic signed [PW-1:0] W_MAX  = PW'((1 << (DW - 1)) - 1);

  typedef logic [N_LSF-1:0][DW-1:0] lsf_vec_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIFF,
    ST_SQ,
    ST_GAIN
  } state_e;

  function automatic logic signed [PW-1:0] rshift_rnd(input logic signed [PW-1:0] v,
                                                      input int unsigned sh);
    return (v + (PW'(1) <<< (sh - 1))) >>> sh;
  endfunction

  function automatic logic [DW-1:0] sat_w(input logic signed [PW-1:0] v);
    if (v > W_MAX) return W_MAX[DW-1:0];
    else if (v < 0) return '0;
    else return v[DW-1:0];
  endfunction
endpackage

// File: rtl/lsfw_gap.sv
module lsfw_gap
  import lsfw_pkg::*;
(
  input  lsf_vec_t                lsf_i,
  input  logic [IDX_W-1:0]        idx_i,
  output logic signed [DW-1:0]    gap_o
);
  localparam logic signed [DW+1:0] RAW_MAX = (DW+2)'((1 << (DW - 1)) - 1);
  localparam logic signed [DW+1:0] RAW_MIN = (DW+2)'(-(1 << (DW - 1)));

  logic signed [DW-1:0] hi, lo;
  logic signed [DW+1:0] raw;

  always_comb begin
    if (idx_i == '0) begin
      hi = lsf_i[1];
      lo = LO_GUARD;
    end else if (idx_i == LAST_IDX) begin
      hi = HI_GUARD;
      lo = lsf_i[N_LSF-2];
    end else begin
      hi = lsf_i[idx_i + 1'b1];
      lo = lsf_i[idx_i - 1'b1];
    end
    raw = (DW+2)'(hi) - (DW+2)'(lo) - (DW+2)'(ONE_IN);
    if (raw > RAW_MAX)      gap_o = RAW_MAX[DW-1:0];
    else if (raw < RAW_MIN) gap_o = RAW_MIN[DW-1:0];
    else                    gap_o = raw[DW-1:0];
  end
endmodule

// File: rtl/lsfw_mul.sv
module lsfw_mul
  import lsfw_pkg::*;
(
  input  logic signed [MW-1:0] a_i,
  input  logic signed [MW-1:0] b_i,
  output logic signed [PW-1:0] p_o
);
  assign p_o = PW'(a_i) * PW'(b_i);
endmodule

// File: rtl/lsfw_ctrl.sv
module lsfw_ctrl
  import lsfw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output state_e           state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             gain_pos_o,
  output logic             capture_o,
  output logic             done_o
);
  state_e           state_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;

  assign gain_pos_o = (idx_q == GAIN_IDX_A) || (idx_q == GAIN_IDX_B);
  assign capture_o  = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_DIFF;
          idx_q   <= '0;
        end
        ST_DIFF: state_q <= ST_SQ;
        ST_SQ: begin
          if (gain_pos_o) begin
            state_q <= ST_GAIN;
          end else if (idx_q == LAST_IDX) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_DIFF;
          end
        end
        ST_GAIN: begin
          if (idx_q == LAST_IDX) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_DIFF;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;
  assign done_o  = done_q;
endmodule

// File: rtl/lsfw_weight_gen.sv
module lsfw_weight_gen
  import lsfw_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [N_LSF*DW-1:0]   lsf_i,
  output logic [N_LSF*DW-1:0]   weight_o,
  output logic                  done_o
);
  state_e               state;
  logic [IDX_W-1:0]     idx;
  logic                 gain_pos, capture, busy;
  lsf_vec_t             lsf_q, wgt_q;
  logic signed [DW-1:0] gap_d, d_q;
  logic signed [MW-1:0] mul_a, mul_b, tmp_q;
  logic signed [PW-1:0] prod, ten_sq, w_sq, tmp_rnd;
  logic [DW-1:0]        w_plain, w_gain;

  lsfw_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .state_o   (state),
    .idx_o     (idx),
    .gain_pos_o(gain_pos),
    .capture_o (capture),
    .done_o    (done_o)
  );

  lsfw_gap u_gap (
    .lsf_i(lsf_q),
    .idx_i(idx),
    .gap_o(gap_d)
  );

  always_comb begin
    if (state == ST_GAIN) begin
      mul_a = tmp_q;
      mul_b = {{(MW-DW){1'b0}}, GAIN_Q};
    end else begin
      mul_a = {{(MW-DW){d_q[DW-1]}}, d_q};
      mul_b = {{(MW-DW){d_q[DW-1]}}, d_q};
    end
  end

  lsfw_mul u_mul (
    .a_i(mul_a),
    .b_i(mul_b),
    .p_o(prod)
  );

  // 10*d^2 by shift-add; penalty only for a negative gap
  assign ten_sq  = (prod <<< 3) + (prod <<< 1);
  assign w_sq    = d_q[DW-1] ? ten_sq + ONE_SQ : ONE_SQ;
  assign w_plain = sat_w(rshift_rnd(w_sq, SQ_FRAC - OUT_FRAC));
  assign tmp_rnd = rshift_rnd(w_sq, SQ_FRAC - IN_FRAC);
  assign w_gain  = sat_w(rshift_rnd(prod, IN_FRAC + GAIN_FRAC - OUT_FRAC));
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lsf_q <= '0;
      d_q   <= '0;
      tmp_q <= '0;
      wgt_q <= '0;
    end else begin
      if (capture) lsf_q <= lsf_i;
      if (state == ST_DIFF) d_q <= gap_d;
      if (state == ST_SQ) tmp_q <= tmp_rnd[MW-1:0];
      if (state == ST_SQ && !gain_pos) wgt_q[idx] <= w_plain;
      else if (state == ST_GAIN) wgt_q[idx] <= w_gain;
    end
  end

  assign weight_o = wgt_q;
endmodule

// File: rtl/lsfw_weight_gen_chk.sv
module lsfw_weight_gen_chk
  import lsfw_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                busy_i,
  input logic                done_i,
  input logic [N_LSF*DW-1:0] weight_i
);
  logic [7:0] lat_q;
  logic       floor_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= '0;
    else if (busy_i) lat_q <= lat_q + 1'b1;
    else lat_q <= '0;
  end

  always_comb begin
    floor_ok = 1'b1;
    for (int k = 0; k < N_LSF; k++)
      if (weight_i[k*DW +: DW] < DW'(1 << OUT_FRAC)) floor_ok = 1'b0;
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R7
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (lat_q < 8'(LAT_LIMIT)));

  // R7
  done_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> $past(busy_i));

  // R8
  weights_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !start_i) |=> $stable(weight_i));

  // R1
  weight_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> floor_ok);
endmodule

bind lsfw_weight_gen lsfw_weight_gen_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_i  (busy),
  .done_i  (done_o),
  .weight_i(weight_o)
);

// File: tb/lsfw_weight_gen_bench.sv
module lsfw_weight_gen_bench;
  import lsfw_pkg::*;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic [N_LSF*DW-1:0] lsf_in = '0;
  logic [N_LSF*DW-1:0] weight;
  logic                done;

  int checks = 0;
  int errors = 0;
  int cur[N_LSF];
  int unsigned seed = 32'h2468ace1;

  always #5 clk = ~clk;

  lsfw_weight_gen u_lsfw_weight_gen (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .lsf_i   (lsf_in),
    .weight_o(weight),
    .done_o  (done)
  );

  function automatic int unsigned rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  function automatic real ref_w(int k, int v[N_LSF]);
    real a, b, d, w;
    if (k == 0) begin
      a = v[1] / 8192.0; b = 1029.0 / 8192.0;
    end else if (k == N_LSF - 1) begin
      a = 23677.0 / 8192.0; b = v[N_LSF-2] / 8192.0;
    end else begin
      a = v[k+1] / 8192.0; b = v[k-1] / 8192.0;
    end
    d = a - b - 1.0;
    if (d < -4.0) d = -4.0;
    w = (d < 0.0) ? 10.0 * d * d + 1.0 : 1.0;
    if (k == 4 || k == 5) w = w * 1.2;
    return w * 128.0;
  endfunction

  function automatic string pos_tag(int k);
    if (k == 0) return "R2";
    if (k == N_LSF - 1) return "R3";
    if (k == 4 || k == 5) return "R4";
    return "R1";
  endfunction

  task automatic drive(input int v[N_LSF]);
    for (int k = 0; k < N_LSF; k++) begin
      lsf_in[k*DW +: DW] = v[k][DW-1:0];
      cur[k] = v[k];
    end
  endtask

  task automatic check_set(input string tag);
    for (int k = 0; k < N_LSF; k++) begin
      real e, g;
      string t;
      e = ref_w(k, cur);
      g = real'(int'(weight[k*DW +: DW]));
      t = (tag == "") ? pos_tag(k) : tag;
      checks++;
      if (g - e > 1.0 || e - g > 1.0) begin
        errors++;
        $display("FAIL %s pos %0d: got %0d expected %f", t, k + 1, int'(weight[k*DW +: DW]), e);
      end
    end
  endtask

  // start on one edge, then count falling edges until done
  task automatic run(input int v[N_LSF], input string tag);
    int lat;
    @(negedge clk);
    drive(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!done && lat < 100);
    checks++;
    if (lat != 22) begin
      errors++;
      $display("FAIL R7 latency: got %0d expected 22", lat);
    end
    check_set(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v[N_LSF];
    int v2[N_LSF];
    int acc;

    // R9 reset state
    repeat (3) @(negedge clk);
    checks++;
    if (done !== 1'b0 || weight !== '0) begin
      errors++;
      $display("FAIL R9 reset: got done=%b weight=%h expected 0", done, weight);
    end
    rst_n = 1'b1;

    // R5 interior gaps exactly 1.0 so d == 0
    for (int k = 0; k < N_LSF; k++) v[k] = -12288 + k * 4096;
    run(v, "");
    for (int k = 1; k < N_LSF - 1; k++) begin
      int want;
      want = (k == 4 || k == 5) ? 154 : 128;
      checks++;
      if (int'(weight[k*DW +: DW]) != want) begin
        errors++;
        $display("FAIL R5 pos %0d: got %0d expected %0d", k + 1, int'(weight[k*DW +: DW]), want);
      end
    end

    // R6 extreme swings force gap saturation
    v = '{31949, -31949, -31949, 31949, 31949, -31949, -31949, 31949, 31949, -31949};
    run(v, "R6");
    checks++;
    if (int'(weight[1*DW +: DW]) != 20608) begin
      errors++;
      $display("FAIL R6 pos 2: got %0d expected 20608", int'(weight[1*DW +: DW]));
    end

    // R2 R3 guard-limited ends only
    v = '{0, 20000, 0, 0, 0, 0, 0, 0, 2000, 0};
    run(v, "");

    // R1 R4 random sorted sets
    for (int n = 0; n < 300; n++) begin
      acc = int'(rnd() % 2458);
      for (int k = 0; k < N_LSF; k++) begin
        v[k] = acc;
        acc += 410 + int'(rnd() % 2458);
        if (acc > 32767) acc = 32767;
      end
      run(v, "");
    end

    // R8 start while busy ignored, then weights held with new inputs
    for (int k = 0; k < N_LSF; k++) v[k] = 1500 + k * 2600;
    for (int k = 0; k < N_LSF; k++) v2[k] = 30000 - k * 3000;
    @(negedge clk);
    drive(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < N_LSF; k++) lsf_in[k*DW +: DW] = v2[k][DW-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int lat;
      lat = 5;
      do begin
        @(negedge clk);
        lat++;
      end while (!done && lat < 100);
      checks++;
      if (lat != 22) begin
        errors++;
        $display("FAIL R8 restart: got done at %0d expected 22", lat);
      end
    end
    check_set("R8");
    begin
      int extra;
      extra = 0;
      repeat (30) begin
        @(negedge clk);
        if (done) extra++;
      end
      checks++;
      if (extra != 0) begin
        errors++;
        $display("FAIL R8 spurious done: got %0d expected 0", extra);
      end
    end
    check_set("R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule